// File: doc/BRIEF.md
# Embedded Core Timer Unit

This block provides the timer facility of a processor core. A free-running 64-bit time base advances by one on each clock cycle while the enable input is high and the freeze input is low. Three timers are derived from it:

- A 32-bit decrementer that can reload itself from a separate reload register.
- A fixed-interval timer that fires on the rising edge of a selectable time-base bit.
- A watchdog that fires on its own selectable time-base bit and escalates in three stages: it first arms, then raises an interrupt, and finally requests a reset.

Software sees four registers through a one-cycle write port and a combinational read port: decrementer, reload value, control and status. Each timer has a status bit and an enable bit. Each interrupt line is the AND of the two. The watchdog reset request carries a two-bit reset type. Reset sequencing and interrupt routing happen outside the block.

Top module: `core_timer_unit`

## Requirements
- R1: After rst_ni is released, the time base, decrementer, reload, control and status registers all read zero, and every interrupt and reset output is low.
- R2: The time base increments by one in each cycle where tb_en_i=1 and freeze_i=0, and it holds its value in every other cycle.
- R3: Register address 0 is the decrementer. On each counting cycle (tb_en_i=1, freeze_i=0) it decrements by one. When it is zero it stays at zero. Writing it loads the written value, and there is no decrement in that cycle. It holds while frozen.
- R4: When the decrementer passes from 1 to 0 on a counting cycle, status bit 0 is set. If control bit 17 (auto-reload) is 1, the decrementer is loaded from the reload register (address 1) instead of becoming 0.
- R5: The fixed-interval selector is s = {ctrl[7:6], ctrl[11:8]}. Status bit 1 is set when time-base bit 63-s goes from 0 to 1, which gives a period of 2^(64-s) ticks.
- R6: Status is at address 3. Writing a 1 to a status bit clears that bit, and writing a 0 leaves it unchanged. If hardware sets a bit in the same cycle it is cleared, the set wins.
- R7: The interrupt lines are computed as follows:
  - dec_irq_o is status[0] & ctrl[15].
  - fit_irq_o is status[1] & ctrl[16].
  - wdt_irq_o is status[2] & ctrl[14].
- R8: The watchdog selector is s = {ctrl[1:0], ctrl[5:2]} and uses the same bit rule as R5. On a watchdog event:
  - If status bit 3 is clear, the event sets it.
  - Otherwise, if status bit 2 is clear, the event sets bit 2.
- R9: A watchdog event that finds status bits 3 and 2 both set, with status[5:4] at zero, copies ctrl[13:12] into status[5:4]. wdt_rst_type_o shows status[5:4], and wdt_rst_req_o is high whenever that field is nonzero. A value of 2'b10 requests a reset, and 2'b00 means no action.
- R10: Register reads are combinational from addr_i. The control register holds bits [17:0], and its upper bits read as zero. The status register holds bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_en_i | input | 1 | Time base enable |
| freeze_i | input | 1 | Debug freeze, stops time base and decrementer |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 dec, 1 reload, 2 ctrl, 3 status) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| timebase_o | output | 64 | Current time base value |
| dec_irq_o | output | 1 | Decrementer interrupt |
| fit_irq_o | output | 1 | Fixed-interval interrupt |
| wdt_irq_o | output | 1 | Watchdog interrupt |
| wdt_rst_req_o | output | 1 | Watchdog reset request |
| wdt_rst_type_o | output | 2 | Requested reset type |

## Verification
The decrementer is tested in two ways: it runs through repeated 1-to-0 crossings with auto-reload on, and it runs down to zero with auto-reload off. These runs tell reload-on-zero apart from stopping at zero. Writes to the decrementer land on counting cycles, which shows that the load takes priority over the decrement. Freeze windows inserted mid-run separate time-base gating from the register path. Status clears are issued with all-ones, all-zeros and single-bit masks, some of them in the same cycle as a hardware event, which shows the write-one-to-clear rule and the set-wins rule. A long watchdog run through all three escalation stages checks the order of the stages and the copied reset type.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int SEL_W = 6;

  typedef enum logic [1:0] {
    ADDR_DEC    = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_STAT   = 2'd3
  } ctu_addr_e;

  typedef struct packed {
    logic       auto_reload;  // 17
    logic       fit_ie;       // 16
    logic       dec_ie;       // 15
    logic       wdt_ie;       // 14
    logic [1:0] wrc;          // 13:12
    logic [3:0] fp_ext;       // 11:8
    logic [1:0] fp;           // 7:6
    logic [3:0] wp_ext;       // 5:2
    logic [1:0] wp;           // 1:0
  } ctu_ctrl_t;

  typedef struct packed {
    logic [1:0] wrs;  // 5:4
    logic       enw;  // 3
    logic       wis;  // 2
    logic       fis;  // 1
    logic       dis;  // 0
  } ctu_stat_t;

  localparam int CTRL_W = $bits(ctu_ctrl_t);
  localparam int STAT_W = $bits(ctu_stat_t);
endpackage

// File: rtl/ctu_timebase.sv
module ctu_timebase #(
  parameter int TB_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [TB_W-1:0] tb_o,
  output logic [TB_W-1:0] tb_nxt_o
);
  logic [TB_W-1:0] tb_q;

  assign tb_nxt_o = tb_q + TB_W'(1);
  assign tb_o     = tb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tb_q <= '0;
    else if (tick_i) tb_q <= tb_nxt_o;
  end
endmodule

// File: rtl/ctu_bit_event.sv
module ctu_bit_event #(
  parameter int TB_W  = 64,
  parameter int SEL_W = 6
) (
  input  logic             tick_i,
  input  logic [TB_W-1:0]  tb_i,
  input  logic [TB_W-1:0]  tb_nxt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  logic [SEL_W-1:0] idx;

  // selector s picks bit TB_W-1-s; zero selects the top bit
  assign idx   = SEL_W'(TB_W - 1) - sel_i;
  assign evt_o = tick_i & tb_nxt_i[idx] & ~tb_i[idx];
endmodule

// File: rtl/ctu_decrementer.sv
module ctu_decrementer #(
  parameter int DEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [DEC_W-1:0] wdata_i,
  input  logic             auto_reload_i,
  input  logic [DEC_W-1:0] reload_i,
  output logic [DEC_W-1:0] dec_o,
  output logic             zero_evt_o
);
  logic [DEC_W-1:0] dec_q, dec_d;
  logic             at_one, at_zero;

  assign at_one     = (dec_q == DEC_W'(1));
  assign at_zero    = (dec_q == '0);
  assign zero_evt_o = tick_i & ~wr_i & at_one;
  assign dec_o      = dec_q;

  always_comb begin
    dec_d = dec_q;
    if (wr_i)                         dec_d = wdata_i;
    else if (zero_evt_o && auto_reload_i) dec_d = reload_i;
    else if (tick_i && !at_zero)      dec_d = dec_q - DEC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dec_q <= '0;
    else         dec_q <= dec_d;
  end
endmodule

// File: rtl/ctu_watchdog.sv
module ctu_watchdog (
  input  logic       evt_i,
  input  logic       enw_i,
  input  logic       wis_i,
  input  logic [1:0] wrs_i,
  output logic       set_enw_o,
  output logic       set_wis_o,
  output logic       set_wrs_o
);
  assign set_enw_o = evt_i & ~enw_i;
  assign set_wis_o = evt_i & enw_i & ~wis_i;
  assign set_wrs_o = evt_i & enw_i & wis_i & (wrs_i == 2'b00);
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
  import ctu_pkg::*;
#(
  parameter int DEC_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tb_en_i,
  input  logic                  freeze_i,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [DEC_W-1:0]      wdata_i,
  output logic [DEC_W-1:0]      rdata_o,
  output logic [2**SEL_W-1:0]   timebase_o,
  output logic                  dec_irq_o,
  output logic                  fit_irq_o,
  output logic                  wdt_irq_o,
  output logic                  wdt_rst_req_o,
  output logic [1:0]            wdt_rst_type_o
);
  localparam int TB_W   = 2**SEL_W;
  localparam int N_EVT  = 2;
  localparam int EV_FIT = 0;
  localparam int EV_WDT = 1;

  logic             tick;
  logic [TB_W-1:0]  tb_nxt;
  logic [DEC_W-1:0] dec_q, reload_q;
  ctu_ctrl_t        ctrl_q;
  ctu_stat_t        stat_q, stat_d;
  logic             dec_wr, reload_wr, ctrl_wr, stat_wr;
  logic             dec_evt;
  logic [N_EVT-1:0][SEL_W-1:0] sel;
  logic [N_EVT-1:0] evt;
  logic             set_enw, set_wis, set_wrs;
  logic [STAT_W-1:0] clr;

  assign tick      = tb_en_i & ~freeze_i;
  assign dec_wr    = we_i & (addr_i == ADDR_DEC);
  assign reload_wr = we_i & (addr_i == ADDR_RELOAD);
  assign ctrl_wr   = we_i & (addr_i == ADDR_CTRL);
  assign stat_wr   = we_i & (addr_i == ADDR_STAT);

  ctu_timebase #(.TB_W(TB_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .tb_o     (timebase_o),
    .tb_nxt_o (tb_nxt)
  );

  assign sel[EV_FIT] = {ctrl_q.fp, ctrl_q.fp_ext};
  assign sel[EV_WDT] = {ctrl_q.wp, ctrl_q.wp_ext};

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    ctu_bit_event #(.TB_W(TB_W), .SEL_W(SEL_W)) u_evt (
      .tick_i   (tick),
      .tb_i     (timebase_o),
      .tb_nxt_i (tb_nxt),
      .sel_i    (sel[g]),
      .evt_o    (evt[g])
    );
  end

  ctu_decrementer #(.DEC_W(DEC_W)) u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .wr_i          (dec_wr),
    .wdata_i       (wdata_i),
    .auto_reload_i (ctrl_q.auto_reload),
    .reload_i      (reload_q),
    .dec_o         (dec_q),
    .zero_evt_o    (dec_evt)
  );

  ctu_watchdog u_wdt (
    .evt_i     (evt[EV_WDT]),
    .enw_i     (stat_q.enw),
    .wis_i     (stat_q.wis),
    .wrs_i     (stat_q.wrs),
    .set_enw_o (set_enw),
    .set_wis_o (set_wis),
    .set_wrs_o (set_wrs)
  );

  // write-one-to-clear, hardware set wins
  assign clr = stat_wr ? wdata_i[STAT_W-1:0] : '0;

  always_comb begin
    stat_d     = ctu_stat_t'(stat_q & ~clr);
    stat_d.dis = stat_d.dis | dec_evt;
    stat_d.fis = stat_d.fis | evt[EV_FIT];
    stat_d.enw = stat_d.enw | set_enw;
    stat_d.wis = stat_d.wis | set_wis;
    if (set_wrs) stat_d.wrs = ctrl_q.wrc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      stat_q   <= '0;
    end else begin
      if (reload_wr) reload_q <= wdata_i;
      if (ctrl_wr)   ctrl_q   <= ctu_ctrl_t'(wdata_i[CTRL_W-1:0]);
      stat_q <= stat_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DEC:    rdata_o = dec_q;
      ADDR_RELOAD: rdata_o = reload_q;
      ADDR_CTRL:   rdata_o = DEC_W'(ctrl_q);
      default:     rdata_o = DEC_W'(stat_q);
    endcase
  end

  assign dec_irq_o      = stat_q.dis & ctrl_q.dec_ie;
  assign fit_irq_o      = stat_q.fis & ctrl_q.fit_ie;
  assign wdt_irq_o      = stat_q.wis & ctrl_q.wdt_ie;
  assign wdt_rst_type_o = stat_q.wrs;
  assign wdt_rst_req_o  = |stat_q.wrs;
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker #(
  parameter int DEC_W = 32,
  parameter int TB_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tb_en_i,
  input logic             freeze_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [TB_W-1:0]  timebase_o,
  input logic [DEC_W-1:0] dec_q,
  input logic [DEC_W-1:0] reload_q,
  input logic [17:0]      ctrl_q,
  input logic [5:0]       stat_q,
  input logic             dec_irq_o,
  input logic             wdt_rst_req_o
);
  logic tick, dec_wr;
  assign tick   = tb_en_i & ~freeze_i;
  assign dec_wr = we_i & (addr_i == 2'd0);

  assert_tb_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> timebase_o == $past(timebase_o) + TB_W'(1));

  assert_tb_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(timebase_o));

  assert_dec_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !dec_wr) |=> $stable(dec_q));

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !dec_wr && dec_q == DEC_W'(1) && ctrl_q[17]) |=> (dec_q == $past(reload_q)) && stat_q[0]);

  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_irq_o |-> (stat_q[0] && ctrl_q[15]));

  assert_wis_after_enw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[2]) |-> $past(stat_q[3]));

  assert_rst_after_wis_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_req_o) |-> $past(stat_q[2] && stat_q[3]));
endmodule

bind core_timer_unit ctu_checker #(.DEC_W(DEC_W), .TB_W(TB_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tb_en_i       (tb_en_i),
  .freeze_i      (freeze_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .timebase_o    (timebase_o),
  .dec_q         (dec_q),
  .reload_q      (reload_q),
  .ctrl_q        (ctrl_q),
  .stat_q        (stat_q),
  .dec_irq_o     (dec_irq_o),
  .wdt_rst_req_o (wdt_rst_req_o)
);

// File: tb/sim_core_timer_unit.sv
module sim_core_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tb_en_i = 1'b0;
  logic        freeze_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] timebase_o;
  logic        dec_irq_o, fit_irq_o, wdt_irq_o, wdt_rst_req_o;
  logic [1:0]  wdt_rst_type_o;

  core_timer_unit u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  // behavioural reference model
  logic [63:0] m_tb;
  logic [31:0] m_dec, m_rel, m_ctrl;
  logic        m_dis, m_fis, m_wis, m_enw;
  logic [1:0]  m_wrs;

  function automatic bit bit_rise(logic [63:0] tb_now, int s);
    int n;
    logic [63:0] nxt;
    n   = 64 - s;
    nxt = tb_now + 64'd1;
    return (nxt << (64 - n)) == (64'h1 << 63);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tb = '0; m_dec = '0; m_rel = '0; m_ctrl = '0;
      m_dis = 0; m_fis = 0; m_wis = 0; m_enw = 0; m_wrs = '0;
    end else begin
      bit tick, fevt, wevt, devt, s_enw, s_wis, s_wrs;
      logic [5:0] clr;
      int fsel, wsel;
      tick = tb_en_i && !freeze_i;
      fsel = int'({m_ctrl[7:6], m_ctrl[11:8]});
      wsel = int'({m_ctrl[1:0], m_ctrl[5:2]});
      fevt = tick && bit_rise(m_tb, fsel);
      wevt = tick && bit_rise(m_tb, wsel);
      devt = 0;
      s_enw = wevt && !m_enw;
      s_wis = wevt && m_enw && !m_wis;
      s_wrs = wevt && m_enw && m_wis && (m_wrs == 0);
      clr = (we_i && addr_i == 2'd3) ? wdata_i[5:0] : 6'd0;
      if (we_i && addr_i == 2'd0) m_dec = wdata_i;
      else if (tick && m_dec != 0) begin
        if (m_dec == 1) begin
          devt = 1;
          m_dec = m_ctrl[17] ? m_rel : 32'd0;
        end else m_dec = m_dec - 1;
      end
      if (clr[0]) m_dis = 0;
      if (clr[1]) m_fis = 0;
      if (clr[2]) m_wis = 0;
      if (clr[3]) m_enw = 0;
      m_wrs = m_wrs & ~clr[5:4];
      if (devt) m_dis = 1;
      if (fevt) m_fis = 1;
      if (s_enw) m_enw = 1;
      if (s_wis) m_wis = 1;
      if (s_wrs) m_wrs = m_ctrl[13:12];
      if (we_i && addr_i == 2'd1) m_rel = wdata_i;
      if (we_i && addr_i == 2'd2) m_ctrl = {14'd0, wdata_i[17:0]};
      if (tick) m_tb = m_tb + 1;
    end
  end

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_dec;
      2'd1: return m_rel;
      2'd2: return m_ctrl;
      default: return {26'd0, m_wrs, m_enw, m_wis, m_fis, m_dis};
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle compare, away from the active edge
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      chk("R2 timebase", timebase_o, m_tb);
      chk(addr_i == 0 ? "R3 dec read" : (addr_i == 3 ? "R6 stat read" : "R10 read"), rdata_o, m_read(addr_i));
      chk("R7 dec_irq", dec_irq_o, m_dis & m_ctrl[15]);
      chk("R7 fit_irq", fit_irq_o, m_fis & m_ctrl[16]);
      chk("R7 wdt_irq", wdt_irq_o, m_wis & m_ctrl[14]);
      chk("R9 rst_req", wdt_rst_req_o, m_wrs != 0);
      chk("R9 rst_type", wdt_rst_type_o, m_wrs);
    end
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk_i); #2;
    we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #2;
    we_i = 0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [31:0] exp);
    @(posedge clk_i); #2;
    addr_i = a;
    @(negedge clk_i);
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    logic [63:0] tb_snap;
    step(3);
    rst_ni = 1;
    // R1: reset state
    rd_chk("R1 dec", 2'd0, 0);
    rd_chk("R1 reload", 2'd1, 0);
    rd_chk("R1 ctrl", 2'd2, 0);
    rd_chk("R1 stat", 2'd3, 0);
    chk("R1 timebase", timebase_o, 0);
    chk("R1 rst_req", wdt_rst_req_o, 0);

    // R10: ctrl keeps only bits 17:0
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R10 ctrl width", 2'd2, 32'h0003_FFFF);
    wr(2'd2, 32'h0);

    // R3: count down to zero and stop without auto-reload
    tb_en_i = 1;
    wr(2'd0, 32'd4);
    step(10);
    rd_chk("R3 stops at zero", 2'd0, 0);
    rd_chk("R4 dec status set", 2'd3, 32'h1);
    // R6: write 0 keeps, write 1 clears
    wr(2'd3, 32'h0);
    rd_chk("R6 zero write keeps", 2'd3, 32'h1);
    wr(2'd3, 32'h1);
    rd_chk("R6 one write clears", 2'd3, 32'h0);

    // R4/R5/R7: auto-reload, fit period 4 (s=62), wdt s=58, reset code 2'b10
    wr(2'd1, 32'd5);
    wr(2'd2, 32'h0003_EEEB);
    wr(2'd0, 32'd3);
    addr_i = 2'd0;
    step(20);
    rd_chk("R5 fit status", 2'd3, {26'd0, m_wrs, m_enw, m_wis, 2'b11});
    chk("R7 dec_irq high", dec_irq_o, 1);
    chk("R7 fit_irq high", fit_irq_o, 1);

    // R2: freeze holds time base and decrementer
    freeze_i = 1;
    step(1);
    tb_snap = timebase_o;
    step(5);
    chk("R2 frozen timebase", timebase_o, tb_snap);
    freeze_i = 0;
    tb_en_i = 0;
    step(3);
    chk("R2 disabled timebase", timebase_o, tb_snap);
    tb_en_i = 1;

    // R3: writes on counting cycles take priority
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, 32'd1 + i);
      step(i);
    end
    // R6: clears mixed with hardware sets
    for (int i = 0; i < 8; i++) begin
      wr(2'd3, 32'h3);
      step(1);
      wr(2'd3, 32'h2);
    end

    // R8/R9: full watchdog escalation, status untouched
    addr_i = 2'd3;
    step(250);
    chk("R8 enw set", m_read(2'd3) >> 3 & 1, 1);
    rd_chk("R8 stage bits", 2'd3, {26'd0, m_wrs, 2'b11, m_fis, m_dis});
    chk("R9 rst_type", wdt_rst_type_o, 2'b10);
    chk("R9 rst_req", wdt_rst_req_o, 1);
    chk("R7 wdt_irq", wdt_irq_o, 1);
    wr(2'd3, 32'h3F);
    step(1);
    chk("R6 rst cleared", wdt_rst_req_o, 0);

    step(50);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule